// File: doc/BRIEF.md
# Byte-Stream to Reduced-Pin Transmit Adapter

This block sits between a MAC that sends one byte per 125 MHz cycle, with a transmit-enable and a transmit-error flag, and a reduced-pin Ethernet PHY. It carries each byte over a four-bit bus, changing value on both clock edges: the low nibble is driven while the clock is high and the high nibble while it is low. Enable and error share one control pin. That pin carries the enable while the clock is high and the exclusive OR of enable and error while it is low.

The PHY needs a forwarded clock, and a mode input chooses which one it gets. A PHY that delays the clock internally is fed a copy of the data clock, aligned to the data edges. A PHY without that delay is fed a quadrature input clock that lags a quarter period and falls in the middle of each data half. Inputs are captured in a single rising-edge register stage. The falling-edge half comes from a negative-edge hold register, so it always launches from settled values.

Top module: `rgmii_tx_adapter`

## Requirements
- R1: Byte, enable and error present at rising edge k are captured at k. Bits 3:0 of the byte appear on the four-bit bus while the clock is high after edge k.
- R2: Bits 7:4 of the byte captured at edge k appear on the four-bit bus while the clock is low after edge k.
- R3: While the clock is high after edge k, the control pin equals the enable captured at k.
- R4: While the clock is low after edge k, the control pin equals enable XOR error captured at k.
- R5: When enable and error are both 0 at capture, the bus is 0 on both halves and the control pin is 0 on both halves, whatever the data byte holds.
- R6: A synchronous active-high reset forces the bus and the control pin to 0 on both halves from the first rising edge at which it is sampled high.
- R7: The forwarded clock keeps toggling while reset is held.
- R8: With mode 0 (edge-aligned), the forwarded clock is high in the high half of the data clock and low in the low half.
- R9: With mode 1 (shifted), the forwarded clock follows the quadrature input, so it is still low early in the data clock's high half and still high early in its low half.
- R10: Error with enable 0 passes the byte through and gives a control pin of 0 in the high half and 1 in the low half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Data clock, 125 MHz nominal |
| clk_q90_i | input | 1 | Same-frequency clock lagging by a quarter period |
| rst_i | input | 1 | Synchronous active-high reset |
| shift_mode_i | input | 1 | 0: forwarded clock edge-aligned, 1: quarter-period shifted |
| tx_byte_i | input | 8 | Byte to send |
| tx_en_i | input | 1 | Transmit enable |
| tx_er_i | input | 1 | Transmit error |
| rg_txd_o | output | 4 | Double-rate data nibble |
| rg_ctl_o | output | 1 | Double-rate control bit |
| rg_clk_o | output | 1 | Forwarded transmit clock |

## Verification
Inputs applied before rising edge k show up in the high half after k, for the low nibble and enable. They show up in the following low half for the high nibble and the folded control bit. No output waits a full extra cycle. The bench drives inputs on falling edges, and the monitor pops the item pushed before edge k at that edge. It samples a quarter period after k for the high half and three quarters after k for the low half, then rebuilds the byte, enable and error from those samples. Clock alignment is checked a little over a tenth of a period into each half. At that point the two modes give opposite levels.

// File: rtl/rgtx_pkg.sv
package rgtx_pkg;

  // Control bit carried during the high half of the clock.
  function automatic logic ctl_rise(input logic en);
    return en;
  endfunction

  // Control bit carried during the low half: enable folded with error.
  function automatic logic ctl_fall(input logic en, input logic er);
    return en ^ er;
  endfunction

  // Idle means neither enable nor error is asserted.
  function automatic logic is_idle(input logic en, input logic er);
    return !en && !er;
  endfunction

endpackage

// File: rtl/rgtx_capture.sv
module rgtx_capture
  import rgtx_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2*NIB_W-1:0] byte_i,
  input  logic               en_i,
  input  logic               er_i,
  output logic [NIB_W:0]     rise_o,
  output logic [NIB_W:0]     fall_o
);
  localparam int BYTE_W = 2 * NIB_W;

  logic             idle;
  logic [NIB_W:0]   rise_d;
  logic [NIB_W:0]   fall_d;

  always_comb begin
    idle   = is_idle(en_i, er_i);
    rise_d = {ctl_rise(en_i), idle ? {NIB_W{1'b0}} : byte_i[NIB_W-1:0]};
    fall_d = {ctl_fall(en_i, er_i), idle ? {NIB_W{1'b0}} : byte_i[BYTE_W-1:NIB_W]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_o <= '0;
      fall_o <= '0;
    end else begin
      rise_o <= rise_d;
      fall_o <= fall_d;
    end
  end

endmodule

// File: rtl/rgtx_ddr_bit.sv
module rgtx_ddr_bit (
  input  logic clk,
  input  logic rise_i,
  input  logic fall_i,
  output logic q_o
);
  logic fall_hold;

  // Falling-edge half launches from a register loaded at the falling edge.
  always_ff @(negedge clk) begin
    fall_hold <= fall_i;
  end

  assign q_o = clk ? rise_i : fall_hold;

endmodule

// File: rtl/rgtx_clk_fwd.sv
module rgtx_clk_fwd (
  input  logic clk,
  input  logic clk_q90,
  input  logic shift_mode,
  output logic clk_o
);
  assign clk_o = shift_mode ? clk_q90 : clk;
endmodule

// File: rtl/rgmii_tx_adapter.sv
module rgmii_tx_adapter #(
  parameter int NIB_W = 4,
  localparam int BYTE_W = 2 * NIB_W,
  localparam int LANES  = NIB_W + 1
) (
  input  logic              clk_i,
  input  logic              clk_q90_i,
  input  logic              rst_i,
  input  logic              shift_mode_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  input  logic              tx_en_i,
  input  logic              tx_er_i,
  output logic [NIB_W-1:0]  rg_txd_o,
  output logic              rg_ctl_o,
  output logic              rg_clk_o
);
  // Named stage wires, visible to the bound checker.
  logic [LANES-1:0] stage_rise;
  logic [LANES-1:0] stage_fall;
  logic [LANES-1:0] lane_q;

  rgtx_capture #(.NIB_W(NIB_W)) u_cap (
    .clk    (clk_i),
    .rst    (rst_i),
    .byte_i (tx_byte_i),
    .en_i   (tx_en_i),
    .er_i   (tx_er_i),
    .rise_o (stage_rise),
    .fall_o (stage_fall)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    rgtx_ddr_bit u_bit (
      .clk    (clk_i),
      .rise_i (stage_rise[g]),
      .fall_i (stage_fall[g]),
      .q_o    (lane_q[g])
    );
  end

  assign rg_txd_o = lane_q[NIB_W-1:0];
  assign rg_ctl_o = lane_q[NIB_W];

  rgtx_clk_fwd u_fwd (
    .clk        (clk_i),
    .clk_q90    (clk_q90_i),
    .shift_mode (shift_mode_i),
    .clk_o      (rg_clk_o)
  );

endmodule

// File: rtl/rgtx_checker.sv
module rgtx_checker #(
  parameter int NIB_W = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [2*NIB_W-1:0] tx_byte,
  input logic               tx_en,
  input logic               tx_er,
  input logic [NIB_W-1:0]   txd,
  input logic               ctl,
  input logic [NIB_W:0]     stage_rise
);
  localparam int BYTE_W = 2 * NIB_W;

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= !rst;

  // Low half after edge k carries the upper nibble captured at k.
  assert_upper_nibble_R2: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(!tx_en && !tx_er) |-> txd == $past(tx_byte[BYTE_W-1:NIB_W]));

  // Low-half control bit is the folded enable/error of edge k.
  assert_fold_ctl_R4: assert property (@(posedge clk) disable iff (rst)
    armed |-> ctl == ($past(tx_en) ^ $past(tx_er)));

  // High half drives the captured low nibble and enable.
  assert_high_half_R1: assert property (@(negedge clk) disable iff (rst)
    armed |-> {ctl, txd} == stage_rise);

  // Idle capture gives a quiet low half.
  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    armed && $past(!tx_en && !tx_er) |-> txd == '0 && !ctl);

  // Error without enable raises the control pin in the low half.
  assert_err_only_R10: assert property (@(posedge clk) disable iff (rst)
    armed && $past(!tx_en && tx_er) |-> ctl);

endmodule

bind rgmii_tx_adapter rgtx_checker #(.NIB_W(NIB_W)) u_chk (
  .clk        (clk_i),
  .rst        (rst_i),
  .tx_byte    (tx_byte_i),
  .tx_en      (tx_en_i),
  .tx_er      (tx_er_i),
  .txd        (rg_txd_o),
  .ctl        (rg_ctl_o),
  .stage_rise (stage_rise)
);

// File: tb/sim_rgmii_tx_adapter.sv
`timescale 1ns/1ps
module sim_rgmii_tx_adapter;

  typedef struct packed {
    logic [7:0] d;
    logic       en;
    logic       er;
  } item_t;

  logic       clk = 1'b0;
  logic       clk_q90 = 1'b0;
  logic       rst = 1'b1;
  logic       mode = 1'b0;
  logic [7:0] tx_byte = '0;
  logic       tx_en = 1'b0;
  logic       tx_er = 1'b0;
  logic [3:0] txd;
  logic       ctl;
  logic       fclk;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  item_t sb[$];

  initial forever #2.5 clk = ~clk;
  initial begin #1.25; forever #2.5 clk_q90 = ~clk_q90; end

  rgmii_tx_adapter u0 (
    .clk_i(clk), .clk_q90_i(clk_q90), .rst_i(rst), .shift_mode_i(mode),
    .tx_byte_i(tx_byte), .tx_en_i(tx_en), .tx_er_i(tx_er),
    .rg_txd_o(txd), .rg_ctl_o(ctl), .rg_clk_o(fclk)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic en, input logic er);
    item_t it;
    @(negedge clk);
    tx_byte = d; tx_en = en; tx_er = er;
    it.d = d; it.en = en; it.er = er;
    sb.push_back(it);
  endtask

  task automatic drain();
    @(negedge clk);
    tx_byte = '0; tx_en = 0; tx_er = 0;
    wait (sb.size() == 0);
    @(posedge clk); #4;
  endtask

  // Monitor: rebuild byte, enable and error from both halves.
  initial forever begin
    item_t exp;
    logic [3:0] lo, hi;
    logic c_hi, c_lo;
    logic [7:0] exp_d;
    @(posedge clk);
    if (sb.size() > 0) begin
      exp = sb.pop_front();
      #1.25; lo = txd; c_hi = ctl;
      #2.5;  hi = txd; c_lo = ctl;
      exp_d = (!exp.en && !exp.er) ? 8'h00 : exp.d;
      chk(lo == exp_d[3:0], "R1 low nibble (R5 when idle)", lo, exp_d[3:0]);
      chk(hi == exp_d[7:4], "R2 high nibble (R5 when idle)", hi, exp_d[7:4]);
      chk(c_hi == exp.en, (!exp.en && exp.er) ? "R10 rise ctl" : "R3 rise ctl", c_hi, exp.en);
      chk((c_hi ^ c_lo) == exp.er, (!exp.en && exp.er) ? "R10 error rebuilt" : "R4 error rebuilt",
          c_hi ^ c_lo, exp.er);
      chk(c_lo == (exp.en ^ exp.er), "R4 fall ctl", c_lo, exp.en ^ exp.er);
    end
  end

  task automatic check_clock(input logic m, input string tag);
    @(posedge clk); #0.6;
    chk(fclk == !m, tag, fclk, !m);
    #2.5;
    chk(fclk == m, tag, fclk, m);
  endtask

  task automatic burst();
    send(8'hA5, 1, 0);
    send(8'h3C, 1, 0);
    send(8'h00, 1, 0);
    send(8'hFF, 1, 0);
    send(8'h5A, 1, 1);
    send(8'h0F, 0, 1);
    send(8'h77, 0, 0);
    for (int i = 0; i < 12; i++) send(8'(i * 37 + 1), 1, i[0]);
    drain();
  endtask

  initial begin
    // R6: reset with busy inputs gives quiet outputs; R7: clock runs.
    tx_byte = 8'hFF; tx_en = 1; tx_er = 1;
    repeat (3) @(posedge clk);
    #1.25;
    chk(txd == 4'h0 && ctl == 1'b0, "R6 reset high half", {ctl, txd}, 0);
    #2.5;
    chk(txd == 4'h0 && ctl == 1'b0, "R6 reset low half", {ctl, txd}, 0);
    check_clock(1'b0, "R7 forwarded clock toggles in reset");
    @(negedge clk);
    rst = 0; tx_byte = '0; tx_en = 0; tx_er = 0;

    mode = 0;
    burst();
    check_clock(1'b0, "R8 edge-aligned clock");

    mode = 1;
    check_clock(1'b1, "R9 shifted clock");
    burst();

    // R6 again mid-run.
    @(negedge clk);
    rst = 1; tx_byte = 8'hC3; tx_en = 1;
    @(posedge clk); #1.25;
    chk(txd == 4'h0 && ctl == 1'b0, "R6 mid-run reset high half", {ctl, txd}, 0);
    #2.5;
    chk(txd == 4'h0 && ctl == 1'b0, "R6 mid-run reset low half", {ctl, txd}, 0);
    check_clock(1'b1, "R7 shifted clock toggles in reset");
    @(negedge clk);
    rst = 0; tx_en = 0; tx_byte = '0;
    mode = 0;
    send(8'h96, 1, 0);
    send(8'h42, 0, 0);
    drain();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule